// File: doc/BRIEF.md
# Twin-Predicate Compress/Expand Sequencer

This block drives an element loop for an operation with one source operand and one destination operand, where each side carries its own predicate mask. It keeps a source index and a destination index that advance independently. Source elements whose mask bit is clear are passed over, and so are destination slots whose mask bit is clear. Each surviving source element is paired with the next open destination slot. The result is a compress followed by an expand, done in one pass. Each pairing leaves the block as a source register number and a destination register number. The data operation itself belongs to the consumer of these pairs.

A caller loads a vector length, two masks, two base register numbers, a flag per side that says whether the mask is used, and a vector/scalar flag per side, all with a single start pulse. The block then emits at most one pair per clock and raises a one-cycle done pulse when the loop ends. A scalar side holds its index at zero. A scalar destination ends the loop after its first transfer. A transfer count reports how many pairs the last operation produced.

Top module: `twin_pred_mover`

## Requirements
- R1: A start pulse while idle captures the whole configuration and raises busy in the next cycle. A start pulse while busy is ignored, and input changes after capture have no effect on the running loop.
- R2: When a side's predicate-enable input is low, that side behaves as if its mask were all ones. An all-ones source mask therefore gives a plain expand, and an all-ones destination mask gives a plain compress.
- R3: With a vector source, every pair's source register is source base plus the index of the next set source-mask bit at or above the current source index. The source index then moves one past that bit.
- R4: With a vector destination, every pair's destination register is destination base plus the index of the next set destination-mask bit at or above the current destination index. The destination index then moves one past that bit.
- R5: A scalar side keeps its index at zero and ignores its mask. Its register number in every pair is its base, and it makes a transfer possible only when the vector length is nonzero.
- R6: With a scalar destination, at most one pair is emitted, and done is raised in the same cycle as that pair.
- R7: The loop ends, with no pair, as soon as either side's next index would be at or beyond the vector length. Mask bits at or above the vector length never produce a pair, and done is a single-cycle pulse.
- R8: Pairs appear on consecutive cycles starting in the second cycle after the start pulse, whatever the number of clear mask bits skipped. With a vector destination, done follows one cycle after the last pair, or in the second cycle when no pair is made.
- R9: The transfer count clears when an operation starts, rises by one with each pair, and holds its final value until the next start.
- R10: A vector length of zero produces no pair and a done pulse in the second cycle after start.
- R11: Register numbers are computed modulo 2 to the power of the register-number width, so base plus index wraps past the top of the register range.
- R12: After reset, busy, the pair-valid output, done and the transfer count are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| vl | input | $clog2(MAXVL+1) | Vector length, 0 to MAXVL |
| src_mask | input | MAXVL | Source predicate, bit k governs source element k |
| src_pred_en | input | 1 | 1: use src_mask, 0: treat as all ones |
| src_base | input | RW | Source base register number |
| src_vec | input | 1 | 1: source is a vector, 0: scalar |
| dst_mask | input | MAXVL | Destination predicate, bit k governs destination slot k |
| dst_pred_en | input | 1 | 1: use dst_mask, 0: treat as all ones |
| dst_base | input | RW | Destination base register number |
| dst_vec | input | 1 | 1: destination is a vector, 0: scalar |
| busy | output | 1 | Operation in progress |
| pair_valid | output | 1 | pair_src/pair_dst hold a transfer this cycle |
| pair_src | output | RW | Source register of the transfer |
| pair_dst | output | RW | Destination register of the transfer |
| done | output | 1 | One-cycle pulse when the loop ends |
| xfer_count | output | $clog2(MAXVL+1) | Pairs emitted by the current or last operation |

## Verification
The bench targets long runs of clear mask bits. A design that skipped them one bit per cycle would open gaps between pairs and move done later. It also drives masks with set bits only above the vector length, where a design that compared against the mask width instead of the vector length would emit pairs past the end. Scalar-destination cases expose a loop that keeps going after its first transfer, and scalar-source cases expose a source index that walks or follows the mask. Starts issued while busy, bases near the top of the register range, and disabled predicates catch a design that reloads its configuration mid-loop, saturates instead of wrapping, or still applies a mask it was told to ignore.

// File: rtl/twp_pkg.sv
package twp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } twp_state_e;
endpackage

// File: rtl/twp_scan.sv
// Finds the lowest set mask bit at or above a starting position in one
// combinational pass (priority encoder over the masked vector).
module twp_scan #(
  parameter int N  = 16,
  parameter int IW = 5
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] from,
  output logic          hit,
  output logic [IW-1:0] pos
);
  localparam logic [IW-1:0] NONE = IW'(N);

  always_comb begin
    hit = 1'b0;
    pos = NONE;
    for (int k = N - 1; k >= 0; k--) begin
      if (mask[k] && (IW'(k) >= from)) begin
        hit = 1'b1;
        pos = IW'(k);
      end
    end
  end

  // R3
  always_comb begin
    if (hit) begin
      scan_hit_set_chk: assert (mask[pos[$clog2(N)-1:0]] && pos >= from && pos < NONE);
    end
  end
endmodule

// File: rtl/twp_side.sv
// One side (source or destination): captured configuration, its index
// and the next candidate element found by the scan.
module twp_side #(
  parameter int N  = 16,
  parameter int IW = 5,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [IW-1:0] vl_q,
  input  logic [N-1:0]  cfg_mask,
  input  logic          cfg_en,
  input  logic [RW-1:0] cfg_base,
  input  logic          cfg_vec,
  output logic          ok,
  output logic [RW-1:0] reg_no,
  output logic          vec_q
);
  logic [IW-1:0] idx;
  logic [N-1:0]  mask_q;
  logic [RW-1:0] base_q;
  logic          hit;
  logic [IW-1:0] pos;
  logic [IW-1:0] cand;

  function automatic logic [RW-1:0] reg_of(input logic [RW-1:0] b,
                                           input logic [IW-1:0] k);
    return b + RW'(k);
  endfunction

  function automatic logic [N-1:0] eff_mask(input logic [N-1:0] m,
                                            input logic en);
    return en ? m : {N{1'b1}};
  endfunction

  twp_scan #(.N(N), .IW(IW)) u_scan (
    .mask(mask_q),
    .from(idx),
    .hit (hit),
    .pos (pos)
  );

  always_comb begin
    cand   = vec_q ? pos : '0;
    ok     = vec_q ? (hit && (pos < vl_q)) : (vl_q != '0);
    reg_no = reg_of(base_q, cand);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      mask_q <= '0;
      base_q <= '0;
      vec_q  <= 1'b0;
    end else if (load) begin
      idx    <= '0;
      mask_q <= eff_mask(cfg_mask, cfg_en);
      base_q <= cfg_base;
      vec_q  <= cfg_vec;
    end else if (adv && vec_q) begin
      idx <= pos + 1'b1;
    end
  end

  // R7
  side_adv_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ok);
  // R5
  side_scalar_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_q |-> (idx == '0));
endmodule

// File: rtl/twp_ctrl.sv
// Loop controller: idle/run state, captured length, step decision,
// transfer count and the registered valid/done strobes.
module twp_ctrl
  import twp_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] vl,
  input  logic          src_ok,
  input  logic          dst_ok,
  input  logic          dst_vec_q,
  output logic          load,
  output logic          adv,
  output logic          busy,
  output logic [IW-1:0] vl_q,
  output logic          valid_q,
  output logic          done_q,
  output logic [IW-1:0] count_q
);
  twp_state_e state;
  logic       step;
  logic       finish;

  always_comb begin
    busy   = (state == ST_RUN);
    load   = start && (state == ST_IDLE);
    step   = (state == ST_RUN);
    adv    = step && src_ok && dst_ok;
    finish = step && (!adv || !dst_vec_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      vl_q    <= '0;
      count_q <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= adv;
      done_q  <= finish;
      if (load) begin
        state   <= ST_RUN;
        vl_q    <= vl;
        count_q <= '0;
      end else begin
        if (finish) state <= ST_IDLE;
        if (adv) count_q <= count_q + 1'b1;
      end
    end
  end

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R1
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> (busy && $stable(vl_q)));
endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover #(
  parameter int MAXVL = 16,
  parameter int RW    = 7,
  localparam int IW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IW-1:0]    vl,
  input  logic [MAXVL-1:0] src_mask,
  input  logic             src_pred_en,
  input  logic [RW-1:0]    src_base,
  input  logic             src_vec,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic             dst_pred_en,
  input  logic [RW-1:0]    dst_base,
  input  logic             dst_vec,
  output logic             busy,
  output logic             pair_valid,
  output logic [RW-1:0]    pair_src,
  output logic [RW-1:0]    pair_dst,
  output logic             done,
  output logic [IW-1:0]    xfer_count
);
  logic          load;
  logic          adv;
  logic [IW-1:0] vl_q;
  logic          src_ok;
  logic          dst_ok;
  logic [RW-1:0] src_reg;
  logic [RW-1:0] dst_reg;
  logic          src_vec_q;
  logic          dst_vec_q;
  logic [RW-1:0] src_out_q;
  logic [RW-1:0] dst_out_q;

  twp_ctrl #(.IW(IW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vl       (vl),
    .src_ok   (src_ok),
    .dst_ok   (dst_ok),
    .dst_vec_q(dst_vec_q),
    .load     (load),
    .adv      (adv),
    .busy     (busy),
    .vl_q     (vl_q),
    .valid_q  (pair_valid),
    .done_q   (done),
    .count_q  (xfer_count)
  );

  twp_side #(.N(MAXVL), .IW(IW), .RW(RW)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .adv     (adv),
    .vl_q    (vl_q),
    .cfg_mask(src_mask),
    .cfg_en  (src_pred_en),
    .cfg_base(src_base),
    .cfg_vec (src_vec),
    .ok      (src_ok),
    .reg_no  (src_reg),
    .vec_q   (src_vec_q)
  );

  twp_side #(.N(MAXVL), .IW(IW), .RW(RW)) u_dst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .adv     (adv),
    .vl_q    (vl_q),
    .cfg_mask(dst_mask),
    .cfg_en  (dst_pred_en),
    .cfg_base(dst_base),
    .cfg_vec (dst_vec),
    .ok      (dst_ok),
    .reg_no  (dst_reg),
    .vec_q   (dst_vec_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_out_q <= '0;
      dst_out_q <= '0;
    end else if (adv) begin
      src_out_q <= src_reg;
      dst_out_q <= dst_reg;
    end
  end

  assign pair_src = src_out_q;
  assign pair_dst = dst_out_q;

  // R6
  scalar_dst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !dst_vec_q) |-> done);
  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (xfer_count == IW'($past(xfer_count) + 1'b1)));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  pair_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(busy));
  // R5
  scalar_src_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !src_vec_q) |-> (pair_src == $past(pair_src) || $past(!pair_valid)));
endmodule

// File: tb/tb_twin_pred_mover.sv
module tb_twin_pred_mover;
  localparam int MAXVL = 16;
  localparam int RW    = 7;
  localparam int IW    = $clog2(MAXVL + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [IW-1:0]    vl = '0;
  logic [MAXVL-1:0] src_mask = '0;
  logic             src_pred_en = 1'b0;
  logic [RW-1:0]    src_base = '0;
  logic             src_vec = 1'b0;
  logic [MAXVL-1:0] dst_mask = '0;
  logic             dst_pred_en = 1'b0;
  logic [RW-1:0]    dst_base = '0;
  logic             dst_vec = 1'b0;
  logic             busy;
  logic             pair_valid;
  logic [RW-1:0]    pair_src;
  logic [RW-1:0]    pair_dst;
  logic             done;
  logic [IW-1:0]    xfer_count;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int exp_n;
  int exp_src [0:16];
  int exp_dst [0:16];

  always #2 clk = ~clk;

  twin_pred_mover #(.MAXVL(MAXVL), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_mask(src_mask), .src_pred_en(src_pred_en), .src_base(src_base), .src_vec(src_vec),
    .dst_mask(dst_mask), .dst_pred_en(dst_pred_en), .dst_base(dst_base), .dst_vec(dst_vec),
    .busy(busy), .pair_valid(pair_valid), .pair_src(pair_src), .pair_dst(pair_dst),
    .done(done), .xfer_count(xfer_count)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference loop, written from the requirements.
  function automatic void model(input int n_vl, input logic [15:0] sm, input logic [15:0] dm,
                                input bit sen, input bit den, input int sb, input int db,
                                input bit sv, input bit dv);
    int i = 0;
    int j = 0;
    logic [15:0] es = sen ? sm : 16'hFFFF;
    logic [15:0] ed = den ? dm : 16'hFFFF;
    exp_n = 0;
    forever begin
      if (sv) while (i < n_vl && !es[i]) i++;
      if (dv) while (j < n_vl && !ed[j]) j++;
      if (i >= n_vl || j >= n_vl) break;
      exp_src[exp_n] = (sb + (sv ? i : 0)) % 128;
      exp_dst[exp_n] = (db + (dv ? j : 0)) % 128;
      exp_n++;
      if (!dv) break;
      if (sv) i++;
      j++;
    end
  endfunction

  task automatic run_op(input string tag, input int n_vl, input logic [15:0] sm,
                        input logic [15:0] dm, input bit sen, input bit den,
                        input int sb, input int db, input bit sv, input bit dv,
                        input bit poke);
    int dcyc;
    bit bad = 1'b0;
    bit seen_done = 1'b0;
    int act_w = 0;
    int exp_w = 0;
    model(n_vl, sm, dm, sen, den, sb, db, sv, dv);
    dcyc = dv ? exp_n + 1 : 1;
    @(negedge clk);
    vl = IW'(n_vl); src_mask = sm; dst_mask = dm; src_pred_en = sen; dst_pred_en = den;
    src_base = RW'(sb); dst_base = RW'(db); src_vec = sv; dst_vec = dv;
    start = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1, "R1", {tag, " busy after start"}, int'(busy), 1);
    if (poke) begin
      start = 1'b1;
      vl = IW'(16); src_mask = ~sm; dst_mask = ~dm; src_pred_en = ~sen; dst_pred_en = ~den;
      src_base = RW'(sb + 5); dst_base = RW'(db + 9); src_vec = ~sv; dst_vec = ~dv;
    end else begin
      start = 1'b0;
    end
    for (int c = 1; c <= 40; c++) begin
      bit ev;
      bit ed;
      @(negedge clk);
      start = 1'b0;
      ev = (c <= exp_n);
      ed = (c == dcyc);
      if (!bad && (pair_valid !== ev || done !== ed ||
                   (ev && (int'(pair_src) != exp_src[c-1] || int'(pair_dst) != exp_dst[c-1])))) begin
        bad = 1'b1;
        act_w = {c[7:0], 6'(0), pair_valid, done, 1'b0, pair_src, 1'b0, pair_dst};
        exp_w = {c[7:0], 6'(0), ev, ed, 1'b0, ev ? 7'(exp_src[c-1]) : pair_src,
                 1'b0, ev ? 7'(exp_dst[c-1]) : pair_dst};
      end
      if (done === 1'b1) begin
        seen_done = 1'b1;
        break;
      end
    end
    chk(!bad && seen_done, tag, "pair sequence", act_w, exp_w);
    chk(int'(xfer_count) == exp_n, "R9", {tag, " count at done"}, int'(xfer_count), exp_n);
    @(negedge clk);
    @(negedge clk);
    chk(int'(xfer_count) == exp_n && busy === 1'b0 && pair_valid === 1'b0,
        "R9", {tag, " count held idle"}, int'(xfer_count), exp_n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && pair_valid === 1'b0 && done === 1'b0 && xfer_count == '0,
        "R12", "reset state", int'({busy, pair_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && xfer_count == '0, "R12", "idle after reset", int'(busy), 0);

    // R2: no predicate on either side, plain vector copy
    run_op("R2 vv nopred", 16, 16'h0000, 16'h0000, 0, 0, 10, 40, 1, 1, 0);
    // R2 R3: compress (destination unpredicated)
    run_op("R2 R3 compress", 12, 16'b0000_1010_0110_1001, 16'h0000, 1, 0, 0, 64, 1, 1, 0);
    // R2 R4: expand (source unpredicated)
    run_op("R2 R4 expand", 16, 16'h0000, 16'b1000_0001_0011_0100, 0, 1, 20, 80, 1, 1, 0);
    // R3 R4: long clear runs on both sides, single-cycle skips
    run_op("R3 R4 R8 twin", 16, 16'b1000_0000_0000_0011, 16'b0100_0000_0001_0001, 1, 1, 5, 6, 1, 1, 0);
    // R5: scalar source splat, mask ignored
    run_op("R5 splat", 10, 16'h0000, 16'b0000_0010_1100_0101, 1, 1, 33, 90, 0, 1, 0);
    // R6: scalar destination selects first set source element
    run_op("R6 select", 16, 16'b0001_0000_0000_0000, 16'hFFFF, 1, 1, 3, 7, 1, 0, 0);
    // R6: scalar on both sides, single transfer
    run_op("R5 R6 scalar", 1, 16'h0000, 16'h0000, 1, 1, 11, 12, 0, 0, 0);
    // R7: set bits only at or above VL
    run_op("R7 above vl", 8, 16'hFF00, 16'hFFFF, 1, 1, 0, 0, 1, 1, 0);
    // R7: destination runs out first
    run_op("R7 dst short", 16, 16'hFFFF, 16'h0007, 1, 1, 0, 100, 1, 1, 0);
    // R10: zero length
    run_op("R10 vl zero", 0, 16'hFFFF, 16'hFFFF, 1, 1, 1, 2, 1, 1, 0);
    run_op("R10 vl zero scalar", 0, 16'hFFFF, 16'hFFFF, 0, 0, 1, 2, 0, 0, 0);
    // R11: register number wrap
    run_op("R11 wrap", 16, 16'hFFFF, 16'hAAAA, 1, 1, 120, 125, 1, 1, 0);
    // R1: start while busy and changed inputs ignored
    run_op("R1 restart ignored", 14, 16'b0011_0101_1100_0110, 16'b0111_0000_1011_1010, 1, 1, 44, 55, 1, 1, 1);

    // Constrained random mix
    void'($urandom(32'h5EED_1234));
    for (int t = 0; t < 400; t++) begin
      int n_vl;
      logic [15:0] sm;
      logic [15:0] dm;
      int dens;
      n_vl = ($urandom % 8 == 0) ? 0 : int'($urandom % 17);
      dens = int'($urandom % 4);
      sm = 16'($urandom);
      dm = 16'($urandom);
      if (dens == 0) begin
        sm = sm & 16'($urandom);
        dm = dm & 16'($urandom);
      end else if (dens == 1) begin
        sm = sm | 16'($urandom);
      end
      run_op("R3 R4 R5 R6 R7 random", n_vl, sm, dm, bit'($urandom % 4 != 0), bit'($urandom % 4 != 0),
             int'($urandom % 128), int'($urandom % 128), bit'($urandom % 4 != 0),
             bit'($urandom % 4 != 0), bit'($urandom % 16 == 0));
    end
    summary();
  end
endmodule